// File: doc/BRIEF.md
# Delay-Slot Illegal Instruction Trap Unit

This block sits in the decode stage of a pipeline with 16-bit instructions and delayed branches. When a flag marks the current instruction as the one sitting in a branch delay slot, the unit looks at its opcode and decides whether that instruction may run there. Some instructions are always forbidden in a slot: anything that moves the program counter, loads that address relative to the program counter, and one reserved undefined code. Control-register and system instructions are forbidden only while the core runs in user mode.

When a slot instruction is forbidden, the unit runs the exception entry in a single commit. It stores the address of the branch that owns the slot, the current status word and the current stack pointer in shadow registers. It writes the slot-fault event code and sets the mode, bank and block bits of the status word. It also produces a redirect target at the vector base plus a fixed offset. A one-cycle strobe tells the rest of the pipeline to take all these values together.

All results are registered, so they show at the outputs one clock after the opcode is decoded. When no trap is taken, every data output keeps its value.

Top module: `slot_trap_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `trap_o` is 0 and every data output is zero.
- R2: In a cycle where `slot_valid_i` is 0, whatever the opcode, `trap_o` is 0 in the next cycle and every data output holds its value.
- R3: In a slot, opcode 0xFFFD traps in either mode.
- R4: In a slot, any instruction that changes the program counter traps in either mode. This covers: 0xAxxx, 0xBxxx, 0x89xx, 0x8Bxx, 0x8Dxx, 0x8Fxx, 0x4m2B, 0x4m0B, 0x0m23, 0x0m03, 0x000B, 0x002B, 0xC3xx, 0x4m0E and 0x4m07.
- R5: In a slot, the system and control-register instructions trap only when status bit 30 is 0 (user mode). These are 0x0038, 0x001B, 0x002B, 0x4mx E, 0x4mx7, 0x0nx2 and 0x4nx3, where x is bits [7:4]. With bit 30 set they do not trap, unless another rule applies.
- R6: The control-register forms whose bits [7:4] equal 0001 (global base register access) do not trap in a slot in either mode.
- R7: In a slot, program-counter-relative loads 0x9xxx and 0xDxxx, and address generation 0xC7xx, trap in either mode.
- R8: In a slot, an opcode that matches none of the rules above does not trap, and all outputs hold.
- R9: On a trap, one cycle after decode, `saved_pc_o` equals the decode-cycle `pc_i` minus 2, modulo 2^32. `saved_sr_o` equals the decode-cycle `sr_i` and `saved_sp_o` equals the decode-cycle `r15_i`.
- R10: On a trap, `event_code_o` becomes 0x000001A0. `status_o` equals the decode-cycle `sr_i` with bits 30, 29 and 28 set and all other bits unchanged.
- R11: On a trap, `redirect_pc_o` equals the decode-cycle `vbr_i` plus 0x100, modulo 2^32.
- R12: Each trapping slot cycle gives exactly one single-cycle `trap_o` pulse, even when several rules match. Back-to-back trapping cycles give one commit each, each with its own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid_i | input | 1 | Current instruction occupies a branch delay slot |
| opcode_i | input | 16 | Opcode being decoded |
| pc_i | input | 32 | Program counter of the slot instruction |
| sr_i | input | 32 | Current status word (bit 30 = privileged mode) |
| r15_i | input | 32 | Current stack pointer |
| vbr_i | input | 32 | Vector base address |
| trap_o | output | 1 | One-cycle commit strobe for the exception entry |
| saved_pc_o | output | 32 | Shadow program counter (address of the owning branch) |
| saved_sr_o | output | 32 | Shadow status word |
| saved_sp_o | output | 32 | Shadow stack pointer |
| event_code_o | output | 32 | Exception event code |
| status_o | output | 32 | Status word to install on entry |
| redirect_pc_o | output | 32 | Fetch redirect target |

## Verification
A decode fault shows one clock after the opcode is presented. It appears either as a missing or extra `trap_o` pulse, or as data outputs that change when no trap should happen. Every opcode class is therefore driven in both modes, with a check on the strobe and on the held outputs in the next cycle. An error in the entry arithmetic shows in that same cycle as a wrong shadow address, status word or redirect target. The bench varies the program counter, stack pointer and vector base on every step, and includes wrap-around values. This way a stale or mis-captured value cannot match by chance.

// File: rtl/slot_trap_pkg.sv
package slot_trap_pkg;

   // Opcode pattern: an opcode matches when (opcode & mask) == value.
   typedef struct packed {
      logic [15:0] mask;
      logic [15:0] value;
   } op_rule_t;

   localparam int OP_W = 16;

   // Instructions that alter the program counter.
   localparam int N_FLOW = 15;
   localparam op_rule_t FLOW_RULES [N_FLOW] = '{
      '{16'hF000, 16'hA000},   // relative branch
      '{16'hF000, 16'hB000},   // relative call
      '{16'hFF00, 16'h8900},   // conditional branch, true
      '{16'hFF00, 16'h8B00},   // conditional branch, false
      '{16'hFF00, 16'h8D00},   // delayed conditional branch, true
      '{16'hFF00, 16'h8F00},   // delayed conditional branch, false
      '{16'hF0FF, 16'h402B},   // register jump
      '{16'hF0FF, 16'h400B},   // register call
      '{16'hF0FF, 16'h0023},   // register-relative branch
      '{16'hF0FF, 16'h0003},   // register-relative call
      '{16'hFFFF, 16'h000B},   // subroutine return
      '{16'hFFFF, 16'h002B},   // exception return
      '{16'hFF00, 16'hC300},   // software trap
      '{16'hF0FF, 16'h400E},   // status load from register
      '{16'hF0FF, 16'h4007}    // status load from memory, post-increment
   };

   // Loads and address generation relative to the program counter.
   localparam int N_PCREL = 3;
   localparam op_rule_t PCREL_RULES [N_PCREL] = '{
      '{16'hFF00, 16'hC700},
      '{16'hF000, 16'h9000},
      '{16'hF000, 16'hD000}
   };

   // Fixed system instructions, privileged.
   localparam int N_SYS = 3;
   localparam op_rule_t SYS_RULES [N_SYS] = '{
      '{16'hFFFF, 16'h0038},   // translation buffer load
      '{16'hFFFF, 16'h001B},   // sleep
      '{16'hFFFF, 16'h002B}    // exception return
   };

   // Control-register transfer families; the selector in bits [7:4]
   // picks the register.
   localparam int N_CTL = 4;
   localparam op_rule_t CTL_RULES [N_CTL] = '{
      '{16'hF00F, 16'h400E},   // load from register
      '{16'hF00F, 16'h4007},   // load from memory
      '{16'hF00F, 16'h0002},   // store to register
      '{16'hF00F, 16'h4003}    // store to memory
   };

   localparam logic [3:0]  GLOBAL_BASE_SEL = 4'h1;
   localparam logic [15:0] RESERVED_TRAP_OP = 16'hFFFD;

endpackage

// File: rtl/slot_op_decoder.sv
module slot_op_decoder
   import slot_trap_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output logic            undef_o,
   output logic            flow_o,
   output logic            pcrel_o,
   output logic            priv_o
);

   logic [N_FLOW-1:0]  flow_hit;
   logic [N_PCREL-1:0] pcrel_hit;
   logic [N_SYS-1:0]   sys_hit;
   logic [N_CTL-1:0]   ctl_hit;
   logic               global_base_sel;

   for (genvar i = 0; i < N_FLOW; i++) begin : g_flow
      assign flow_hit[i] = (op_i & FLOW_RULES[i].mask) == FLOW_RULES[i].value;
   end

   for (genvar i = 0; i < N_PCREL; i++) begin : g_pcrel
      assign pcrel_hit[i] = (op_i & PCREL_RULES[i].mask) == PCREL_RULES[i].value;
   end

   for (genvar i = 0; i < N_SYS; i++) begin : g_sys
      assign sys_hit[i] = (op_i & SYS_RULES[i].mask) == SYS_RULES[i].value;
   end

   for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
      assign ctl_hit[i] = (op_i & CTL_RULES[i].mask) == CTL_RULES[i].value;
   end

   assign global_base_sel = (op_i[7:4] == GLOBAL_BASE_SEL);

   assign undef_o = (op_i == RESERVED_TRAP_OP);
   assign flow_o  = |flow_hit;
   assign pcrel_o = |pcrel_hit;
   assign priv_o  = (|sys_hit) | ((|ctl_hit) & ~global_base_sel);

endmodule

// File: rtl/slot_trap_policy.sv
module slot_trap_policy (
   input  logic slot_i,
   input  logic priv_mode_i,
   input  logic undef_i,
   input  logic flow_i,
   input  logic pcrel_i,
   input  logic priv_i,
   output logic fault_o
);

   logic always_bad;
   logic mode_bad;

   // Classes forbidden in a slot whatever the mode.
   assign always_bad = undef_i | flow_i | pcrel_i;
   // System classes forbidden only in user mode.
   assign mode_bad   = priv_i & ~priv_mode_i;
   // Several causes still raise a single fault.
   assign fault_o    = slot_i & (always_bad | mode_bad);

endmodule

// File: rtl/slot_trap_commit.sv
module slot_trap_commit #(
   parameter int             XLEN       = 32,
   parameter int             INSN_BYTES = 2,
   parameter logic [XLEN-1:0] EVT_CODE  = 'h1A0,
   parameter logic [XLEN-1:0] VEC_OFF   = 'h100,
   parameter logic [XLEN-1:0] SET_MASK  = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fault_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] sr_i,
   input  logic [XLEN-1:0] sp_i,
   input  logic [XLEN-1:0] vbr_i,
   output logic            trap_o,
   output logic [XLEN-1:0] saved_pc_o,
   output logic [XLEN-1:0] saved_sr_o,
   output logic [XLEN-1:0] saved_sp_o,
   output logic [XLEN-1:0] event_code_o,
   output logic [XLEN-1:0] status_o,
   output logic [XLEN-1:0] redirect_pc_o
);

   localparam logic [XLEN-1:0] BACK_STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] branch_pc;
   logic [XLEN-1:0] vector_pc;

   assign branch_pc = pc_i - BACK_STEP;
   assign vector_pc = vbr_i + VEC_OFF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_o        <= 1'b0;
         saved_pc_o    <= '0;
         saved_sr_o    <= '0;
         saved_sp_o    <= '0;
         event_code_o  <= '0;
         status_o      <= '0;
         redirect_pc_o <= '0;
      end else begin
         trap_o <= fault_i;
         if (fault_i) begin
            saved_pc_o    <= branch_pc;
            saved_sr_o    <= sr_i;
            saved_sp_o    <= sp_i;
            event_code_o  <= EVT_CODE;
            status_o      <= sr_i | SET_MASK;
            redirect_pc_o <= vector_pc;
         end
      end
   end

endmodule

// File: rtl/slot_trap_unit.sv
module slot_trap_unit #(
   parameter int              XLEN       = 32,
   parameter int              INSN_BYTES = 2,
   parameter int              MODE_BIT   = 30,
   parameter int              BANK_BIT   = 29,
   parameter int              BLOCK_BIT  = 28,
   parameter logic [XLEN-1:0] EVT_CODE   = 'h1A0,
   parameter logic [XLEN-1:0] VEC_OFF    = 'h100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slot_valid_i,
   input  logic [15:0]     opcode_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] sr_i,
   input  logic [XLEN-1:0] r15_i,
   input  logic [XLEN-1:0] vbr_i,
   output logic            trap_o,
   output logic [XLEN-1:0] saved_pc_o,
   output logic [XLEN-1:0] saved_sr_o,
   output logic [XLEN-1:0] saved_sp_o,
   output logic [XLEN-1:0] event_code_o,
   output logic [XLEN-1:0] status_o,
   output logic [XLEN-1:0] redirect_pc_o
);

   localparam logic [XLEN-1:0] ONE      = XLEN'(1);
   localparam logic [XLEN-1:0] SET_MASK = (ONE << MODE_BIT) | (ONE << BANK_BIT)
                                        | (ONE << BLOCK_BIT);

   // Elaboration-time parameter checks.
   if (XLEN < 16) begin : g_bad_xlen
      $error("slot_trap_unit: XLEN must be at least 16");
   end
   if (MODE_BIT >= XLEN || BANK_BIT >= XLEN || BLOCK_BIT >= XLEN) begin : g_bad_bit
      $error("slot_trap_unit: status bit position outside XLEN");
   end
   if (MODE_BIT == BANK_BIT || MODE_BIT == BLOCK_BIT || BANK_BIT == BLOCK_BIT) begin : g_dup_bit
      $error("slot_trap_unit: status bit positions must differ");
   end
   if (INSN_BYTES < 1) begin : g_bad_step
      $error("slot_trap_unit: INSN_BYTES must be positive");
   end

   logic is_undef;
   logic is_flow;
   logic is_pcrel;
   logic is_priv;
   logic fault;

   slot_op_decoder u_dec (
      .op_i    (opcode_i),
      .undef_o (is_undef),
      .flow_o  (is_flow),
      .pcrel_o (is_pcrel),
      .priv_o  (is_priv)
   );

   slot_trap_policy u_pol (
      .slot_i      (slot_valid_i),
      .priv_mode_i (sr_i[MODE_BIT]),
      .undef_i     (is_undef),
      .flow_i      (is_flow),
      .pcrel_i     (is_pcrel),
      .priv_i      (is_priv),
      .fault_o     (fault)
   );

   slot_trap_commit #(
      .XLEN       (XLEN),
      .INSN_BYTES (INSN_BYTES),
      .EVT_CODE   (EVT_CODE),
      .VEC_OFF    (VEC_OFF),
      .SET_MASK   (SET_MASK)
   ) u_commit (
      .clk           (clk),
      .rst_n         (rst_n),
      .fault_i       (fault),
      .pc_i          (pc_i),
      .sr_i          (sr_i),
      .sp_i          (r15_i),
      .vbr_i         (vbr_i),
      .trap_o        (trap_o),
      .saved_pc_o    (saved_pc_o),
      .saved_sr_o    (saved_sr_o),
      .saved_sp_o    (saved_sp_o),
      .event_code_o  (event_code_o),
      .status_o      (status_o),
      .redirect_pc_o (redirect_pc_o)
   );

endmodule

// File: rtl/slot_trap_chk.sv
module slot_trap_chk #(
   parameter int              XLEN       = 32,
   parameter int              INSN_BYTES = 2,
   parameter int              MODE_BIT   = 30,
   parameter int              BANK_BIT   = 29,
   parameter int              BLOCK_BIT  = 28,
   parameter logic [XLEN-1:0] EVT_CODE   = 'h1A0,
   parameter logic [XLEN-1:0] VEC_OFF    = 'h100
) (
   input logic            clk,
   input logic            rst_n,
   input logic            slot_valid_i,
   input logic [15:0]     opcode_i,
   input logic [XLEN-1:0] pc_i,
   input logic [XLEN-1:0] sr_i,
   input logic [XLEN-1:0] r15_i,
   input logic [XLEN-1:0] vbr_i,
   input logic            trap_o,
   input logic [XLEN-1:0] saved_pc_o,
   input logic [XLEN-1:0] saved_sr_o,
   input logic [XLEN-1:0] saved_sp_o,
   input logic [XLEN-1:0] event_code_o,
   input logic [XLEN-1:0] status_o,
   input logic [XLEN-1:0] redirect_pc_o
);

   // R2
   slot_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid_i |=> (!trap_o && $stable(saved_pc_o) && $stable(saved_sr_o)
                         && $stable(saved_sp_o) && $stable(event_code_o)
                         && $stable(status_o) && $stable(redirect_pc_o)));

   // R9
   reserved_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid_i && opcode_i == 16'hFFFD) |=>
         (trap_o && saved_pc_o == $past(pc_i) - XLEN'(INSN_BYTES)
          && saved_sr_o == $past(sr_i) && saved_sp_o == $past(r15_i)));

   // R10
   entry_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (event_code_o == EVT_CODE && status_o[MODE_BIT]
                  && status_o[BANK_BIT] && status_o[BLOCK_BIT]));

   // R11
   redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid_i && opcode_i == 16'hFFFD) |=> redirect_pc_o == $past(vbr_i) + VEC_OFF);

   // R5
   user_system_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid_i && opcode_i == 16'h0038 && !sr_i[MODE_BIT]) |=> trap_o);

   // R5
   kernel_system_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid_i && opcode_i == 16'h0038 && sr_i[MODE_BIT]) |=> !trap_o);

   // R7
   pcrel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid_i && opcode_i[15:12] == 4'h9) |=> trap_o);

endmodule

bind slot_trap_unit slot_trap_chk #(
   .XLEN       (XLEN),
   .INSN_BYTES (INSN_BYTES),
   .MODE_BIT   (MODE_BIT),
   .BANK_BIT   (BANK_BIT),
   .BLOCK_BIT  (BLOCK_BIT),
   .EVT_CODE   (EVT_CODE),
   .VEC_OFF    (VEC_OFF)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .slot_valid_i  (slot_valid_i),
   .opcode_i      (opcode_i),
   .pc_i          (pc_i),
   .sr_i          (sr_i),
   .r15_i         (r15_i),
   .vbr_i         (vbr_i),
   .trap_o        (trap_o),
   .saved_pc_o    (saved_pc_o),
   .saved_sr_o    (saved_sr_o),
   .saved_sp_o    (saved_sp_o),
   .event_code_o  (event_code_o),
   .status_o      (status_o),
   .redirect_pc_o (redirect_pc_o)
);

// File: tb/slot_trap_unit_tb.sv
`timescale 1ns/1ps
module slot_trap_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slot_valid_i = 1'b0;
   logic [15:0] opcode_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] sr_i = '0;
   logic [31:0] r15_i = '0;
   logic [31:0] vbr_i = '0;
   logic        trap_o;
   logic [31:0] saved_pc_o, saved_sr_o, saved_sp_o;
   logic [31:0] event_code_o, status_o, redirect_pc_o;

   int checks = 0;
   int errors = 0;
   int step_n = 0;
   bit done = 1'b0;

   // Bench-side copy of the last committed entry values.
   logic [31:0] m_pc = '0, m_sr = '0, m_sp = '0, m_evt = '0, m_st = '0, m_rd = '0;

   always #2 clk = ~clk;

   slot_trap_unit u_dut (
      .clk (clk), .rst_n (rst_n), .slot_valid_i (slot_valid_i),
      .opcode_i (opcode_i), .pc_i (pc_i), .sr_i (sr_i), .r15_i (r15_i),
      .vbr_i (vbr_i), .trap_o (trap_o), .saved_pc_o (saved_pc_o),
      .saved_sr_o (saved_sr_o), .saved_sp_o (saved_sp_o),
      .event_code_o (event_code_o), .status_o (status_o),
      .redirect_pc_o (redirect_pc_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(input string req, input logic exp_trap);
      chk(req, "trap", {31'd0, trap_o}, {31'd0, exp_trap});
      chk(req, "saved_pc", saved_pc_o, m_pc);
      chk(req, "saved_sr", saved_sr_o, m_sr);
      chk(req, "saved_sp", saved_sp_o, m_sp);
      chk(req, "event", event_code_o, m_evt);
      chk(req, "status", status_o, m_st);
      chk(req, "redirect", redirect_pc_o, m_rd);
   endtask

   // Drive one decode cycle with explicit context, then check the next cycle.
   task automatic step_ctx(input logic [15:0] op, input logic slot, input logic kmode,
                           input logic [31:0] pc, input logic [31:0] sr_base,
                           input logic [31:0] sp, input logic [31:0] vbr,
                           input logic exp_trap, input string req);
      logic [31:0] sr_v;
      sr_v = kmode ? (sr_base | 32'h4000_0000) : (sr_base & ~32'h4000_0000);
      @(negedge clk);
      slot_valid_i = slot; opcode_i = op; pc_i = pc; sr_i = sr_v;
      r15_i = sp; vbr_i = vbr;
      @(posedge clk);
      #1;
      if (exp_trap) begin
         m_pc = pc - 32'd2; m_sr = sr_v; m_sp = sp; m_evt = 32'h0000_01A0;
         m_st = sr_v | 32'h7000_0000; m_rd = vbr + 32'h100;
      end
      check_outputs(req, exp_trap);
   endtask

   // Drive one decode cycle with varying context values.
   task automatic step(input logic [15:0] op, input logic slot, input logic kmode,
                       input logic exp_trap, input string req);
      step_n++;
      step_ctx(op, slot, kmode, 32'h8C00_1000 + 32'(step_n * 6),
               32'h0000_00F0 ^ 32'(step_n), 32'h7FFF_0000 - 32'(step_n * 4),
               32'h8000_0000 + 32'(step_n << 12), exp_trap, req);
   endtask

   task automatic t_reset();
      // R1
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check_outputs("R1", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_outputs("R1", 1'b0);
   endtask

   task automatic t_reserved();
      // R3
      step(16'hFFFD, 1'b1, 1'b0, 1'b1, "R3");
      step(16'hFFFD, 1'b1, 1'b1, 1'b1, "R3");
   endtask

   task automatic t_flow();
      logic [15:0] ops [15] = '{16'hA123, 16'hB456, 16'h8912, 16'h8B34, 16'h8D56,
                                16'h8F78, 16'h432B, 16'h450B, 16'h0623, 16'h0703,
                                16'h000B, 16'h002B, 16'hC320, 16'h410E, 16'h4207};
      // R4
      for (int i = 0; i < 15; i++) begin
         step(ops[i], 1'b1, 1'b0, 1'b1, "R4");
         step(ops[i], 1'b1, 1'b1, 1'b1, "R4");
      end
   endtask

   task automatic t_system();
      logic [15:0] ops [6] = '{16'h0038, 16'h001B, 16'h412E, 16'h4237,
                               16'h0322, 16'h4343};
      // R5
      for (int i = 0; i < 6; i++) begin
         step(ops[i], 1'b1, 1'b0, 1'b1, "R5");
         step(ops[i], 1'b1, 1'b1, 1'b0, "R5");
      end
   endtask

   task automatic t_global_base();
      logic [15:0] ops [4] = '{16'h411E, 16'h4217, 16'h0312, 16'h4413};
      // R6
      for (int i = 0; i < 4; i++) begin
         step(ops[i], 1'b1, 1'b0, 1'b0, "R6");
         step(ops[i], 1'b1, 1'b1, 1'b0, "R6");
      end
   endtask

   task automatic t_pcrel();
      logic [15:0] ops [3] = '{16'hC712, 16'h9345, 16'hD678};
      // R7
      for (int i = 0; i < 3; i++) begin
         step(ops[i], 1'b1, 1'b0, 1'b1, "R7");
         step(ops[i], 1'b1, 1'b1, 1'b1, "R7");
      end
   endtask

   task automatic t_legal();
      logic [15:0] ops [5] = '{16'h0009, 16'h312C, 16'hE501, 16'h6053, 16'hFFFE};
      // R8
      for (int i = 0; i < 4; i++) begin
         step(ops[i], 1'b1, 1'b0, 1'b0, "R8");
         step(ops[i], 1'b1, 1'b1, 1'b0, "R8");
      end
      step(ops[4 - 1], 1'b1, 1'b0, 1'b0, "R8");
   endtask

   task automatic t_no_slot();
      // R2
      step(16'hFFFD, 1'b0, 1'b0, 1'b0, "R2");
      step(16'hA000, 1'b0, 1'b1, 1'b0, "R2");
      step(16'h0038, 1'b0, 1'b0, 1'b0, "R2");
      step(16'h9111, 1'b0, 1'b1, 1'b0, "R2");
   endtask

   task automatic t_entry_values();
      // R9: program counter at zero wraps below zero
      step_ctx(16'hFFFD, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_00F3,
               32'h1234_5678, 32'h0000_0000, 1'b1, "R9");
      // R10: other status bits preserved, set bits already set
      step_ctx(16'hA000, 1'b1, 1'b1, 32'h0000_0002, 32'hF000_0F0F,
               32'h0, 32'h4000_0000, 1'b1, "R10");
      // R11: vector base near the top wraps
      step_ctx(16'hC700, 1'b1, 1'b0, 32'hFFFF_FFFE, 32'h0000_0001,
               32'hFFFF_FFFF, 32'hFFFF_FF80, 1'b1, "R11");
   endtask

   task automatic t_strobe();
      // R12: user-mode exception return matches two rules, one pulse
      step(16'h002B, 1'b1, 1'b0, 1'b1, "R12");
      step(16'h0009, 1'b0, 1'b0, 1'b0, "R12");
      // R12: back-to-back commits, each with its own values
      step(16'hFFFD, 1'b1, 1'b0, 1'b1, "R12");
      step(16'hB001, 1'b1, 1'b1, 1'b1, "R12");
      step(16'h0009, 1'b1, 1'b0, 1'b0, "R12");
   endtask

   initial begin
      t_reset();
      t_no_slot();
      t_reserved();
      t_flow();
      t_system();
      t_global_base();
      t_pcrel();
      t_legal();
      t_entry_values();
      t_strobe();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule